// File: doc/BRIEF.md
# ADC Conversion and Calibration Sequencer

This block is the control state machine of a self-calibrating serial analog-to-digital converter. It runs from one master clock and steps its states on an internal enable at half that rate. After reset it waits through a fixed settling interval. It then idles in standby until it gets a command. A command runs either a two-phase calibration (an offset phase, then a gain phase) or a conversion. A conversion runs once, or repeats for as long as the convert pin stays high. The modulator, the filter arithmetic and the coefficient math are not part of this block. A tick counter stands in for their run time.

Commands come from rising edges on the convert pin. The level of the calibrate pin on that edge selects the command. Both pins and the polarity pin pass through a synchroniser before they are used. A command that arrives during the settling interval is held and runs when the interval ends. Each active phase drives its own strobe. A one-cycle pulse marks the end of a calibration. When a conversion ends, a one-cycle load-pending strobe goes to the serial port, and a load pulse follows it two cycles later. Every duration is a parameter in master clock cycles and must be even. The defaults are 1800 cycles to settle, 3246 to calibrate and 1622 for each conversion. Simulation uses smaller values with the same ordering.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset no strobe is active before clock edge WAKE_CYC. A command whose pin edge arrives during that interval starts its phase at edge WAKE_CYC exactly. Edges are counted from 1 at the first rising edge after reset is released.
- R2: A convert-pin rise with the calibrate pin high starts calibration. A rise with the calibrate pin low starts conversion. Let k be the first edge that samples the new pin level. The phase strobe rises at the first even-numbered edge at or after k+3.
- R3: The offset strobe lasts 2*floor(CAL_CYC/4) cycles. The gain strobe follows directly and lasts for the rest of CAL_CYC. At most one of the offset, gain and convert strobes is high at any time.
- R4: cal_done is high for one cycle, on the edge where the gain strobe falls. If the synchronised convert pin is high at that edge, the convert strobe rises on the same edge. If it is low, the block returns to standby.
- R5: During calibration, a convert-pin rise with the calibrate pin high restarts the offset phase, and cal_done then comes CAL_CYC cycles after the restart edge. A rise with the calibrate pin low is discarded: the calibration ends on schedule and no conversion follows.
- R6: A conversion started from standby or after settling raises load_pending exactly CONV_CYC+2 cycles after the convert strobe rises.
- R7: While the convert pin stays high, load_pending repeats every CONV_CYC cycles and the convert strobe stays high. If the pin is low at the end of a conversion, the convert strobe falls on the load_pending edge.
- R8: A convert-pin rise during a conversion restarts it. The update scheduled for edge T is suppressed if and only if the pin was first sampled high at an edge k with k <= T-3.
- R9: load_word is a one-cycle pulse, exactly two cycles after each load_pending pulse.
- R10: word_bipolar takes the synchronised polarity pin value on the cycle load_pending is high, and holds it until the next update.
- R11: Reset clears any held command. With no new command, no strobe rises after the settling interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_pin | input | 1 | Calibrate qualifier, asynchronous |
| conv_pin | input | 1 | Convert command, rising edge, asynchronous |
| bipolar_pin | input | 1 | Output polarity select, asynchronous |
| ofs_cal | output | 1 | Offset calibration phase active |
| gain_cal | output | 1 | Gain calibration phase active |
| converting | output | 1 | Conversion phase active |
| cal_done | output | 1 | One-cycle end-of-calibration pulse |
| load_pending | output | 1 | One-cycle strobe that lets the serial port raise its ready flag |
| load_word | output | 1 | One-cycle pulse that loads the word, two cycles after load_pending |
| word_bipolar | output | 1 | Polarity that applies to the loaded word |

## Verification
Two events can fall on the same state tick: the natural end of a conversion and a new convert command that restarts it. The bench starts conversions from standby and moves the second convert-pin rise across seven edges around the scheduled end, one edge per run. For each run it predicts from the edge count whether the held command reaches the final tick, which suppresses the update, or arrives too late, so that the update fires on schedule. It compares load_pending with that prediction. A similar clash during calibration, between a restart command and a discarded convert command, is judged by when cal_done arrives.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    SQ_WAKE, SQ_IDLE, SQ_OFS, SQ_GAIN, SQ_ARM, SQ_CONV
  } seq_state_t;

  typedef enum logic [1:0] {
    CMD_NONE, CMD_CAL, CMD_CONV
  } seq_cmd_t;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic [W-1:0] r;
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) r <= '0;
          else        r <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) r <= '0;
          else        r <= g_stage[i-1].r;
      end
    end
  endgenerate

  assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/adc_seq_cmd.sv
module adc_seq_cmd
  import adc_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cal_s,
  input  logic     conv_s,
  input  logic     consume,
  output seq_cmd_t pend
);
  logic conv_q;
  logic conv_rise;

  assign conv_rise = conv_s & ~conv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_q <= 1'b0;
      pend   <= CMD_NONE;
    end else begin
      conv_q <= conv_s;
      if (conv_rise)    pend <= cal_s ? CMD_CAL : CMD_CONV;
      else if (consume) pend <= CMD_NONE;
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int WAKE_CYC = 1800,
  parameter int CAL_CYC  = 3246,
  parameter int CONV_CYC = 1622
) (
  input  logic     clk,
  input  logic     rst_n,
  input  seq_cmd_t pend,
  input  logic     conv_lvl,
  output logic     consume,
  output logic     st_ofs,
  output logic     st_gain,
  output logic     st_conv,
  output logic     cal_end,
  output logic     upd
);
  localparam int WK_T   = WAKE_CYC / 2;
  localparam int CAL_T  = CAL_CYC / 2;
  localparam int OFS_T  = CAL_T / 2;
  localparam int GAIN_T = CAL_T - OFS_T;
  localparam int CNV_T  = CONV_CYC / 2;
  localparam int MAXT   = (WK_T > CAL_T) ? ((WK_T > CNV_T) ? WK_T : CNV_T)
                                         : ((CAL_T > CNV_T) ? CAL_T : CNV_T);
  localparam int CW     = (MAXT < 2) ? 1 : $clog2(MAXT + 1);

  localparam logic [CW-1:0] WK_LD   = CW'(WK_T - 1);
  localparam logic [CW-1:0] OFS_LD  = CW'(OFS_T - 1);
  localparam logic [CW-1:0] GAIN_LD = CW'(GAIN_T - 1);
  localparam logic [CW-1:0] CNV_LD  = CW'(CNV_T - 1);

  seq_state_t    st, nxt_st;
  logic [CW-1:0] cnt, nxt_cnt;
  logic          tick;
  logic          cal_end_n, upd_n;
  logic          cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= ~tick;
  end

  always_comb begin
    nxt_st    = st;
    nxt_cnt   = cnt;
    consume   = 1'b0;
    cal_end_n = 1'b0;
    upd_n     = 1'b0;
    if (tick) begin
      case (st)
        SQ_WAKE: begin
          if (cnt_zero) begin
            consume = 1'b1;
            if (pend == CMD_CAL) begin
              nxt_st  = SQ_OFS;
              nxt_cnt = OFS_LD;
            end else if (pend == CMD_CONV) begin
              nxt_st = SQ_ARM;
            end else begin
              nxt_st = SQ_IDLE;
            end
          end else begin
            nxt_cnt = cnt - 1'b1;
          end
        end
        SQ_IDLE: begin
          consume = 1'b1;
          if (pend == CMD_CAL) begin
            nxt_st  = SQ_OFS;
            nxt_cnt = OFS_LD;
          end else if (pend == CMD_CONV) begin
            nxt_st = SQ_ARM;
          end
        end
        SQ_OFS, SQ_GAIN: begin
          consume = 1'b1;
          if (pend == CMD_CAL) begin
            nxt_st  = SQ_OFS;
            nxt_cnt = OFS_LD;
          end else if (!cnt_zero) begin
            nxt_cnt = cnt - 1'b1;
          end else if (st == SQ_OFS) begin
            nxt_st  = SQ_GAIN;
            nxt_cnt = GAIN_LD;
          end else begin
            cal_end_n = 1'b1;
            if (conv_lvl) begin
              nxt_st  = SQ_CONV;
              nxt_cnt = CNV_LD;
            end else begin
              nxt_st = SQ_IDLE;
            end
          end
        end
        SQ_ARM, SQ_CONV: begin
          consume = 1'b1;
          if (pend == CMD_CAL) begin
            nxt_st  = SQ_OFS;
            nxt_cnt = OFS_LD;
          end else if (pend == CMD_CONV) begin
            nxt_st = SQ_ARM;
          end else if (st == SQ_ARM) begin
            nxt_st  = SQ_CONV;
            nxt_cnt = CNV_LD;
          end else if (!cnt_zero) begin
            nxt_cnt = cnt - 1'b1;
          end else begin
            upd_n = 1'b1;
            if (conv_lvl) begin
              nxt_st  = SQ_CONV;
              nxt_cnt = CNV_LD;
            end else begin
              nxt_st = SQ_IDLE;
            end
          end
        end
        default: nxt_st = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_WAKE;
      cnt     <= WK_LD;
      cal_end <= 1'b0;
      upd     <= 1'b0;
    end else begin
      st      <= nxt_st;
      cnt     <= nxt_cnt;
      cal_end <= cal_end_n;
      upd     <= upd_n;
    end
  end

  assign st_ofs  = (st == SQ_OFS);
  assign st_gain = (st == SQ_GAIN);
  assign st_conv = (st == SQ_ARM) || (st == SQ_CONV);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int WAKE_CYC    = 1800,
  parameter int CAL_CYC     = 3246,
  parameter int CONV_CYC    = 1622,
  parameter int SYNC_STAGES = 2,
  parameter int LOAD_LAG    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_pin,
  input  logic conv_pin,
  input  logic bipolar_pin,
  output logic ofs_cal,
  output logic gain_cal,
  output logic converting,
  output logic cal_done,
  output logic load_pending,
  output logic load_word,
  output logic word_bipolar
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] pins_s;
  logic            cal_s, conv_s, bp_s;
  logic            consume;
  seq_cmd_t        pend;

  adc_seq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .d({bipolar_pin, conv_pin, cal_pin}),
    .q(pins_s)
  );
  assign {bp_s, conv_s, cal_s} = pins_s;

  adc_seq_cmd i_cmd (
    .clk(clk), .rst_n(rst_n),
    .cal_s(cal_s), .conv_s(conv_s),
    .consume(consume), .pend(pend)
  );

  adc_seq_fsm #(.WAKE_CYC(WAKE_CYC), .CAL_CYC(CAL_CYC), .CONV_CYC(CONV_CYC)) i_fsm (
    .clk(clk), .rst_n(rst_n),
    .pend(pend), .conv_lvl(conv_s),
    .consume(consume),
    .st_ofs(ofs_cal), .st_gain(gain_cal), .st_conv(converting),
    .cal_end(cal_done), .upd(load_pending)
  );

  adc_seq_sync #(.W(1), .STAGES(LOAD_LAG)) i_lag (
    .clk(clk), .rst_n(rst_n),
    .d(load_pending), .q(load_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            word_bipolar <= 1'b0;
    else if (load_pending) word_bipolar <= bp_s;
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ofs_cal,
  input logic gain_cal,
  input logic converting,
  input logic cal_done,
  input logic load_pending,
  input logic load_word
);
  assert_phase_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ofs_cal, gain_cal, converting}));

  assert_gain_after_ofs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gain_cal) |-> $past(ofs_cal));

  assert_caldone_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> ($past(gain_cal) && !gain_cal));

  assert_caldone_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done);

  assert_update_in_conv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_pending |-> $past(converting));

  assert_update_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_pending |=> !load_pending);

  assert_load_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_word |-> $past(load_pending, 2));
endmodule

bind adc_seq_ctrl adc_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n),
  .ofs_cal(ofs_cal), .gain_cal(gain_cal), .converting(converting),
  .cal_done(cal_done), .load_pending(load_pending), .load_word(load_word)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int WK     = 40;
  localparam int CALC   = 46;
  localparam int CNV    = 30;
  localparam int OFS_C  = 2 * ((CALC / 2) / 2);
  localparam int GAIN_C = CALC - OFS_C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_pin = 1'b0, conv_pin = 1'b0, bipolar_pin = 1'b0;
  logic ofs_cal, gain_cal, converting, cal_done, load_pending, load_word, word_bipolar;

  int ecnt;
  int n_tot = 0;
  int n_bad = 0;

  adc_seq_ctrl #(.WAKE_CYC(WK), .CAL_CYC(CALC), .CONV_CYC(CNV)) i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cal_pin(cal_pin), .conv_pin(conv_pin),
    .bipolar_pin(bipolar_pin), .ofs_cal(ofs_cal), .gain_cal(gain_cal),
    .converting(converting), .cal_done(cal_done), .load_pending(load_pending),
    .load_word(load_word), .word_bipolar(word_bipolar)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tot++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, ecnt);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
    $finish;
  endtask

  function automatic int first_even(input int e);
    return (e % 2 == 0) ? e : e + 1;
  endfunction

  task automatic to_edge(input int e);
    while (ecnt < e) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cal_pin = 1'b0; conv_pin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tot++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int k, s, t, r, c0, cend, bad, n;
    do_reset();
    chk(!ofs_cal && !gain_cal && !converting && !cal_done && !load_pending && !load_word,
        "R1 reset state", ofs_cal + gain_cal + converting + load_pending, 0);

    // Phase A: calibration held through the settling interval, then continuous conversion
    to_edge(5);
    cal_pin = 1'b1; conv_pin = 1'b1; bipolar_pin = 1'b1;
    bad = 0;
    do begin
      @(negedge clk);
      if (ecnt < WK && (ofs_cal || gain_cal || converting)) bad++;
    end while (ecnt < WK);
    chk(bad == 0, "R1 quiet while settling", bad, 0);
    chk(ofs_cal == 1'b1, "R1 deferred calibration starts", ofs_cal, 1);
    cal_pin = 1'b0;
    n = 0;
    while (ofs_cal && n < 1000) begin n++; @(negedge clk); end
    chk(n == OFS_C, "R3 offset length", n, OFS_C);
    chk(gain_cal == 1'b1, "R3 gain follows offset", gain_cal, 1);
    n = 0;
    while (gain_cal && n < 1000) begin n++; @(negedge clk); end
    chk(n == GAIN_C, "R3 gain length", n, GAIN_C);
    chk(cal_done == 1'b1, "R4 cal_done at gain end", cal_done, 1);
    chk(converting == 1'b1, "R4 conversion follows with pin high", converting, 1);
    cend = ecnt;
    @(negedge clk);
    chk(cal_done == 1'b0, "R4 cal_done width", cal_done, 0);

    for (int i = 0; i < 3; i++) begin
      t = cend + CNV * (i + 1);
      bad = 0;
      while (ecnt < t) begin
        if (load_pending) bad++;
        @(negedge clk);
      end
      chk(bad == 0 && load_pending == 1'b1, "R7 continuous update spacing", load_pending, 1);
      chk(converting == (i < 2), "R7 strobe state at update", converting, (i < 2) ? 1 : 0);
      if (i == 0) bipolar_pin = 1'b0;
      if (i == 1) conv_pin = 1'b0;
      @(negedge clk);
      chk(word_bipolar == (i == 0), "R10 polarity captured", word_bipolar, (i == 0) ? 1 : 0);
      chk(load_word == 1'b0, "R9 load not early", load_word, 0);
      @(negedge clk);
      chk(load_word == 1'b1, "R9 load two cycles later", load_word, 1);
      @(negedge clk);
      chk(load_word == 1'b0, "R9 load width", load_word, 0);
    end

    // Phase B: single conversion from standby
    repeat (10) @(negedge clk);
    bipolar_pin = 1'b1;
    repeat (5) @(negedge clk);
    k = ecnt + 1;
    conv_pin = 1'b1;
    s = first_even(k + 3);
    while (!converting && ecnt < k + 20) @(negedge clk);
    chk(ecnt == s, "R2 conversion start latency", ecnt, s);
    conv_pin = 1'b0;
    t = s + 2 + CNV;
    bad = 0;
    while (ecnt < t) begin
      if (load_pending) bad++;
      @(negedge clk);
    end
    chk(bad == 0 && load_pending == 1'b1, "R6 standby conversion length", load_pending, 1);
    @(negedge clk);
    chk(word_bipolar == 1'b1, "R10 polarity high captured", word_bipolar, 1);
    chk(converting == 1'b0, "R7 back to standby", converting, 0);

    // Phase C: calibration restart with CAL high
    repeat (10) @(negedge clk);
    cal_pin = 1'b1; conv_pin = 1'b1;
    k = ecnt + 1;
    c0 = first_even(k + 3);
    repeat (4) @(negedge clk);
    conv_pin = 1'b0;
    to_edge(c0);
    chk(ofs_cal == 1'b1, "R2 calibration start latency", ofs_cal, 1);
    to_edge(c0 + 10);
    conv_pin = 1'b1;
    r = first_even(ecnt + 1 + 3);
    repeat (4) @(negedge clk);
    conv_pin = 1'b0;
    bad = 0;
    while (ecnt < r + CALC) begin
      if (cal_done) bad++;
      @(negedge clk);
    end
    chk(bad == 0 && cal_done == 1'b1, "R5 restart moves cal_done", cal_done, 1);
    chk(converting == 1'b0, "R4 standby when pin low", converting, 0);
    cal_pin = 1'b0;

    // Phase C2: convert edge with CAL low during calibration is discarded
    repeat (10) @(negedge clk);
    cal_pin = 1'b1; conv_pin = 1'b1;
    k = ecnt + 1;
    c0 = first_even(k + 3);
    repeat (4) @(negedge clk);
    conv_pin = 1'b0; cal_pin = 1'b0;
    to_edge(c0 + OFS_C + 4);
    conv_pin = 1'b1;
    repeat (4) @(negedge clk);
    conv_pin = 1'b0;
    bad = 0;
    while (ecnt < c0 + CALC) begin
      if (cal_done) bad++;
      @(negedge clk);
    end
    chk(bad == 0 && cal_done == 1'b1, "R5 ignored edge keeps schedule", cal_done, 1);
    repeat (10) @(negedge clk);
    chk(converting == 1'b0, "R5 discarded command runs nothing", converting, 0);

    // Phase D: retrigger swept around the end of a conversion
    for (int off = -5; off <= 1; off++) begin
      int kk;
      bit exp_upd;
      repeat (60) @(negedge clk);
      k = ecnt + 1;
      conv_pin = 1'b1;
      s = first_even(k + 3);
      repeat (4) @(negedge clk);
      conv_pin = 1'b0;
      t = s + 2 + CNV;
      kk = t + off;
      to_edge(kk - 1);
      conv_pin = 1'b1;
      to_edge(t);
      exp_upd = (kk >= t - 2);
      chk(load_pending == exp_upd, "R8 retrigger versus end", load_pending, exp_upd);
      repeat (3) @(negedge clk);
      conv_pin = 1'b0;
      repeat (120) @(negedge clk);
    end

    // Phase E: reset clears a held command
    @(negedge clk);
    conv_pin = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b0; conv_pin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bad = 0;
    while (ecnt < WK + 40) begin
      @(negedge clk);
      if (ofs_cal || gain_cal || converting) bad++;
    end
    chk(bad == 0, "R11 reset drops held command", bad, 0);

    // Phase F: conversion command during settling
    do_reset();
    to_edge(10);
    conv_pin = 1'b1;
    repeat (4) @(negedge clk);
    conv_pin = 1'b0;
    to_edge(WK - 1);
    chk(converting == 1'b0, "R1 no early conversion", converting, 0);
    to_edge(WK);
    chk(converting == 1'b1, "R1 deferred conversion starts", converting, 1);
    to_edge(WK + 2 + CNV);
    chk(load_pending == 1'b1, "R6 deferred conversion length", load_pending, 1);

    summary();
  end
endmodule